// File: doc/BRIEF.md
# Linear Delta Modulation Encoder

This block turns a stream of signed multi-bit samples into a one-bit-per-sample code. It keeps a staircase estimate of the input in a register. On every sample strobe it compares the new sample against that estimate. The estimate then moves one fixed step toward the sample, and the direction of the move is sent out as a single bit. A matching decoder rebuilds the staircase by adding or subtracting the same step for each received bit. It needs no other information from the encoder.

The step size is fixed at elaboration time through a parameter. Samples may arrive on any clock cycle, with idle cycles in between. The estimate only changes on cycles that carry a sample. Each coded bit is registered and comes out with its own valid strobe one clock after the sample that produced it.

Top module: `dm_encoder`

## Requirements
- R1: Each cycle with `smp_vld` high produces exactly one `dm_vld` pulse on the following clock. A cycle with `smp_vld` low produces `dm_vld` low on the following clock.
- R2: A synchronous active-high `rst` sets the staircase estimate to zero and drives `dm_vld` and `dm_bit` low on the next clock.
- R3: When the sample, read as two's complement, is strictly greater than the current estimate, `dm_bit` is 1 and the estimate rises by `STEP`.
- R4: When the sample is equal to or less than the current estimate, `dm_bit` is 0 and the estimate falls by `STEP`. Equality counts as the falling case.
- R5: The estimate changes only on cycles with `smp_vld` high. Idle cycles leave it unchanged, so the next bit is computed against the same value.
- R6: A rise that would pass the largest signed value of width `W` holds the estimate at that largest value.
- R7: A fall that would pass the smallest signed value of width `W` holds the estimate at that smallest value.
- R8: The sample-minus-estimate difference is formed one bit wider than `W`. Its sign is therefore correct across the full range, for example a sample of the minimum value against an estimate at the maximum gives bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Sample strobe |
| smp_data | input | W | Signed two's complement sample |
| dm_bit | output | 1 | Coded bit, 1 = step up, 0 = step down |
| dm_vld | output | 1 | Coded bit valid, one clock after `smp_vld` |

## Verification
The bench builds the encoder with `W` = 8 and `STEP` = 20. With these values the estimate reaches both rails within about seven samples of a full-scale input. Both saturation clamps are therefore exercised many times, including the case where the step is larger than the remaining headroom. The 8-bit range also makes the extreme comparisons cheap to reach: the maximum estimate against the minimum sample, and exact ties between sample and estimate.

// File: rtl/dm_enc_pkg.sv
package dm_enc_pkg;
  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } dm_dir_e;
endpackage

// File: rtl/dm_err_slicer.sv
module dm_err_slicer
  import dm_enc_pkg::*;
#(
  parameter int W = 12
) (
  input  logic signed [W-1:0] smp,
  input  logic signed [W-1:0] approx,
  output dm_dir_e             dir
);
  localparam int EW = W + 1;

  logic signed [EW-1:0] diff;

  // widened difference: sign is exact across the full input range (R8)
  always_comb begin
    diff = {smp[W-1], smp} - {approx[W-1], approx};
    dir  = (!diff[EW-1] && (diff != '0)) ? DIR_UP : DIR_DOWN;
  end
endmodule

// File: rtl/dm_stair_acc.sv
module dm_stair_acc
  import dm_enc_pkg::*;
#(
  parameter int W    = 12,
  parameter int STEP = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  dm_dir_e             dir,
  output logic signed [W-1:0] approx
);
  localparam int AW = W + 2;
  localparam logic signed [W-1:0]  MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0]  MINV = {1'b1, {(W-1){1'b0}}};
  localparam logic signed [AW-1:0] MAXX = {3'b000, {(W-1){1'b1}}};
  localparam logic signed [AW-1:0] MINX = {3'b111, {(W-1){1'b0}}};
  localparam logic signed [AW-1:0] STPX = AW'(STEP);

  logic signed [AW-1:0] ext;
  logic signed [AW-1:0] sum;
  logic signed [W-1:0]  approx_n;

  always_comb begin
    ext = {{2{approx[W-1]}}, approx};
    sum = (dir == DIR_UP) ? (ext + STPX) : (ext - STPX);
    if (sum > MAXX)      approx_n = MAXV;
    else if (sum < MINX) approx_n = MINV;
    else                 approx_n = sum[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)     approx <= '0;
    else if (en) approx <= approx_n;
  end

  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(en)) |-> $stable(approx)); // R5

  AST_ACC_UP_SAT: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(en) && $past(dir) == DIR_UP)
      |-> (approx > $past(approx) || approx == MAXV)); // R6

  AST_ACC_DN_SAT: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(en) && $past(dir) == DIR_DOWN)
      |-> (approx < $past(approx) || approx == MINV)); // R7
endmodule

// File: rtl/dm_encoder.sv
module dm_encoder
  import dm_enc_pkg::*;
#(
  parameter int W    = 12,
  parameter int STEP = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         smp_vld,
  input  logic [W-1:0] smp_data,
  output logic         dm_bit,
  output logic         dm_vld
);
  logic signed [W-1:0] approx;
  dm_dir_e             dir;

  dm_err_slicer #(.W(W)) u_slicer (
    .smp    ($signed(smp_data)),
    .approx (approx),
    .dir    (dir)
  );

  dm_stair_acc #(.W(W), .STEP(STEP)) u_acc (
    .clk    (clk),
    .rst    (rst),
    .en     (smp_vld),
    .dir    (dir),
    .approx (approx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dm_vld <= 1'b0;
      dm_bit <= 1'b0;
    end else begin
      dm_vld <= smp_vld;
      if (smp_vld) dm_bit <= (dir == DIR_UP);
    end
  end

  AST_VLD_LAT: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (dm_vld == $past(smp_vld))); // R1

  AST_RST_CLR: assert property (@(posedge clk)
    $past(rst) |-> (!dm_vld && !dm_bit && approx == '0)); // R2

  AST_UP_BIT: assert property (@(posedge clk) disable iff (rst)
    (smp_vld && $signed(smp_data) > approx) |=> dm_bit); // R3

  AST_DOWN_BIT: assert property (@(posedge clk) disable iff (rst)
    (smp_vld && $signed(smp_data) <= approx) |=> !dm_bit); // R4
endmodule

// File: tb/dm_encoder_tb.sv
`timescale 1ns/1ps
module dm_encoder_tb;
  localparam int W    = 8;
  localparam int STEP = 20;
  localparam int MAXI = (1 << (W-1)) - 1;
  localparam int MINI = -(1 << (W-1));

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         smp_vld = 1'b0;
  logic [W-1:0] smp_data = '0;
  logic         dm_bit;
  logic         dm_vld;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // behavioural reference
  int    m_acc = 0;
  bit    e_vld = 1'b0;
  bit    e_bit = 1'b0;
  string e_req = "R2";

  always #2.5 clk = ~clk;

  dm_encoder #(.W(W), .STEP(STEP)) u_dut (
    .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_data(smp_data),
    .dm_bit(dm_bit), .dm_vld(dm_vld)
  );

  task automatic compare();
    checks++;
    if (dm_vld !== e_vld || (e_vld && dm_bit !== e_bit) ||
        (e_req == "R2" && dm_bit !== 1'b0)) begin
      errors++;
      $display("FAIL %s: vld=%0b bit=%0b expected vld=%0b bit=%0b",
               e_req, dm_vld, dm_bit, e_vld, e_bit);
    end
  endtask

  // compare previous cycle's result, then drive this cycle and update model
  task automatic cyc(input bit do_rst, input bit vld, input int val);
    @(negedge clk);
    compare();
    rst      = do_rst;
    smp_vld  = vld;
    smp_data = W'(val);
    if (do_rst) begin
      m_acc = 0; e_vld = 1'b0; e_bit = 1'b0; e_req = "R2";
    end else if (vld) begin
      int nxt;
      e_vld = 1'b1;
      e_bit = (val > m_acc);
      if (val > m_acc) begin nxt = m_acc + STEP; e_req = "R3"; end
      else begin nxt = m_acc - STEP; e_req = "R4"; end
      if (val == MINI && m_acc == MAXI) e_req = "R8";
      if (nxt > MAXI) begin nxt = MAXI; e_req = "R6"; end
      if (nxt < MINI) begin nxt = MINI; e_req = "R7"; end
      m_acc = nxt;
    end else begin
      e_vld = 1'b0; e_req = "R1";
    end
  endtask

  initial begin
    cyc(1, 0, 0);
    cyc(1, 1, 50);
    cyc(0, 0, 0);                                 // reset state (R2)
    for (int i = 0; i < 8; i++) cyc(0, 1, 100);   // ramp, then tie at 100 (R4)
    for (int i = 0; i < 10; i++) cyc(0, 1, MAXI); // upper clamp (R6)
    cyc(0, 1, MINI);                              // full-range diff (R8)
    for (int i = 0; i < 3; i++) cyc(0, 0, 77);    // idle, hold (R1, R5)
    for (int i = 0; i < 14; i++) cyc(0, 1, MINI); // lower clamp (R7)
    cyc(0, 1, MAXI);
    for (int i = 0; i < 60; i++)                  // tracking, gappy stream
      cyc(0, (i % 4) != 3, ((i * 37) % 200) - 100);
    cyc(0, 1, 10);
    cyc(1, 1, 10);                                // mid-run reset (R2)
    cyc(0, 1, 1);                                 // 1 > 0 after clear
    cyc(0, 1, 0);
    cyc(0, 0, 0);
    cyc(0, 0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule